// File: doc/BRIEF.md
# SPI Serial Clock Ratio Generator

This block derives the serial clock of an SPI controller from its peripheral clock. A small index code chooses the divide ratio. In table mode the index walks a ladder of ratios that grows alternately by a factor of 1.5 and by a factor of 4/3, starting at 3. In power-of-two mode the low three index bits choose a ratio of four times a power of two. Software picks the smallest ratio for which the requested rate times the ratio reaches the peripheral clock rate, so the serial clock never runs faster than requested. The block clamps any index the selected variant cannot use.

Along with the serial clock the block emits two single-cycle strobes: a sample strobe in the cycle the clock leaves its idle level, and a shift strobe in the cycle it returns to idle. A shift register elsewhere uses them. Changes to the index, the mode pins and the polarity are taken up only at the start of a serial-clock period. Dropping the enable parks the clock at its idle level at once. There is no data path, so every pin is a plain level control.

Top module: `sclk_ratio_gen`

## Requirements
- R1: While `rst_n` is low, `sclk`, `sample_stb` and `shift_stb` are all 0.
- R2: One cycle after an edge with `en` low, `sclk` equals `cpol` as it was at that edge, and both strobes are 0.
- R3: In table mode (`pow2_sel`=0), with `idx` from 2 to the cap, the period is 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512, 768 or 1024 cycles for index 2, 3, 4 and so on up to 18. The period is measured as the number of cycles from one `sample_stb` to the next.
- R4: Index 1 gives a period of 3 only when `div3_allow`=1. Otherwise it acts as index 2. Index 0 always acts as index 2.
- R5: In table mode an index above the cap acts as the cap. The cap is 16 when `wide_cap`=0 and 18 when `wide_cap`=1.
- R6: In power-of-two mode (`pow2_sel`=1) the period is 4·2^c, where c is `idx[2:0]`. The upper index bits have no effect.
- R7: Within a period of D cycles, `sclk` sits at the active level (the inverse of the period's `cpol`) for ceil(D/2) cycles, then at the idle level for floor(D/2) cycles.
- R8: `sample_stb` is high exactly in the first active cycle of a period. `shift_stb` is high exactly in the first idle cycle. The two are never high together, and two `sample_stb` pulses are at least 3 cycles apart.
- R9: A change of `idx`, mode or `cpol` while enabled does not alter the period in progress. The new setting applies from the next `sample_stb`.
- R10: In the cycle after the first edge with `en` high, `sample_stb` is 1 and a period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run the serial clock |
| idx | input | 5 | Ratio index code |
| pow2_sel | input | 1 | 1 selects power-of-two mode |
| wide_cap | input | 1 | Table cap: 0 gives 16, 1 gives 18 |
| div3_allow | input | 1 | Allows index 1 (ratio 3) |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| sample_stb | output | 1 | Leading-edge strobe |
| shift_stb | output | 1 | Trailing-edge strobe |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a running period, because the effect must show up only one boundary later. The stimulus lines up on an observed `sample_stb`, changes the index or polarity in that same cycle, and then times two whole periods back to back: the first must keep the old ratio and level, the second must use the new ones. Odd ratio 3 and the clamp at both caps are reached by directed cases. Random configurations then cover the rest of the index space.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;
  localparam int IDX_W      = 5;
  localparam int CNT_W      = 11;
  localparam int NARROW_CAP = 16;
  localparam int WIDE_CAP   = 18;
  localparam int P2_W       = 3;

  // Ratio ladder: position 1 is the odd step, positions from 2 alternate
  // base 4 and base 6, doubling every two positions.
  function automatic int table_ratio(input int pos);
    int step;
    if (pos == 1) return 3;
    if (pos < 2) return 4;
    step = pos - 2;
    return ((step % 2) != 0 ? 6 : 4) << (step / 2);
  endfunction
endpackage

// File: rtl/sclkdiv_ratio.sv
module sclkdiv_ratio #(
  parameter int IDX_W      = sclkdiv_pkg::IDX_W,
  parameter int CNT_W      = sclkdiv_pkg::CNT_W,
  parameter int NARROW_CAP = sclkdiv_pkg::NARROW_CAP,
  parameter int WIDE_CAP   = sclkdiv_pkg::WIDE_CAP,
  parameter int P2_W       = sclkdiv_pkg::P2_W
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             pow2_sel,
  input  logic             wide_cap,
  input  logic             div3_allow,
  output logic [CNT_W-1:0] ratio
);
  localparam int ENTRIES = 2 ** IDX_W;
  localparam logic [IDX_W-1:0] CAP_LO   = IDX_W'(NARROW_CAP);
  localparam logic [IDX_W-1:0] CAP_HI   = IDX_W'(WIDE_CAP);
  localparam logic [IDX_W-1:0] POS_ODD  = IDX_W'(1);
  localparam logic [IDX_W-1:0] POS_BASE = IDX_W'(2);
  localparam logic [CNT_W-1:0] P2_BASE  = CNT_W'(4);

  logic [CNT_W-1:0] tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
    assign tbl[g] = CNT_W'(sclkdiv_pkg::table_ratio(g));
  end

  logic [IDX_W-1:0] cap;
  logic [IDX_W-1:0] pos;

  always_comb begin
    cap = wide_cap ? CAP_HI : CAP_LO;
    pos = (idx > cap) ? cap : idx;
    if (pos == '0 || (pos == POS_ODD && !div3_allow))
      pos = POS_BASE;
  end

  assign ratio = pow2_sel ? (P2_BASE << idx[P2_W-1:0]) : tbl[pos];
endmodule

// File: rtl/sclkdiv_phase.sv
module sclkdiv_phase #(
  parameter int CNT_W = sclkdiv_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cpol,
  input  logic [CNT_W-1:0] ratio,
  output logic             sclk,
  output logic             sample_stb,
  output logic             shift_stb
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio_q;
  logic [CNT_W-1:0] lead_q;
  logic             pol_q;
  logic             running;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] lead_new;
  logic             at_end;

  assign cnt_nxt  = cnt + 1'b1;
  assign lead_new = ratio - (ratio >> 1);
  assign at_end   = (cnt_nxt == ratio_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      ratio_q    <= '0;
      lead_q     <= '0;
      pol_q      <= 1'b0;
      running    <= 1'b0;
      sclk       <= 1'b0;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else if (!en) begin
      cnt        <= '0;
      running    <= 1'b0;
      sclk       <= cpol;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else if (!running || at_end) begin
      cnt        <= '0;
      ratio_q    <= ratio;
      lead_q     <= lead_new;
      pol_q      <= cpol;
      running    <= 1'b1;
      sclk       <= ~cpol;
      sample_stb <= 1'b1;
      shift_stb  <= 1'b0;
    end else begin
      cnt        <= cnt_nxt;
      sample_stb <= 1'b0;
      shift_stb  <= (cnt_nxt == lead_q);
      if (cnt_nxt == lead_q)
        sclk <= pol_q;
    end
  end
endmodule

// File: rtl/sclk_ratio_gen.sv
module sclk_ratio_gen #(
  parameter int IDX_W      = sclkdiv_pkg::IDX_W,
  parameter int CNT_W      = sclkdiv_pkg::CNT_W,
  parameter int NARROW_CAP = sclkdiv_pkg::NARROW_CAP,
  parameter int WIDE_CAP   = sclkdiv_pkg::WIDE_CAP,
  parameter int P2_W       = sclkdiv_pkg::P2_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  input  logic             pow2_sel,
  input  logic             wide_cap,
  input  logic             div3_allow,
  input  logic             cpol,
  output logic             sclk,
  output logic             sample_stb,
  output logic             shift_stb
);
  logic [CNT_W-1:0] ratio;

  sclkdiv_ratio #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .NARROW_CAP(NARROW_CAP),
    .WIDE_CAP(WIDE_CAP), .P2_W(P2_W)
  ) u_ratio (
    .idx(idx), .pow2_sel(pow2_sel), .wide_cap(wide_cap),
    .div3_allow(div3_allow), .ratio(ratio)
  );

  sclkdiv_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .ratio(ratio),
    .sclk(sclk), .sample_stb(sample_stb), .shift_stb(shift_stb)
  );
endmodule

// File: rtl/sclkdiv_chk.sv
module sclkdiv_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cpol,
  input logic sclk,
  input logic sample_stb,
  input logic shift_stb
);
  logic [1:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      gap  <= 2'd0;
      seen <= 1'b0;
    end else begin
      if (sample_stb) seen <= 1'b1;
      if (sample_stb) gap <= 2'd0;
      else if (gap != 2'd3) gap <= gap + 2'd1;
    end
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk == $past(cpol)) && !sample_stb && !shift_stb);

  // R10
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> sample_stb);

  // R8
  min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sample_stb && seen) |-> (gap >= 2'd2));

  // R8
  shift_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> (sclk != $past(sclk)));

  // R8
  shift_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> seen);
endmodule

bind sclk_ratio_gen sclkdiv_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol),
  .sclk(sclk), .sample_stb(sample_stb), .shift_stb(shift_stb)
);

// File: tb/test_sclk_ratio_gen.sv
module test_sclk_ratio_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [4:0] idx;
  logic       pow2_sel, wide_cap, div3_allow, cpol;
  logic       sclk, sample_stb, shift_stb;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sclk_ratio_gen i_sclk_ratio_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .idx(idx), .pow2_sel(pow2_sel),
    .wide_cap(wide_cap), .div3_allow(div3_allow), .cpol(cpol),
    .sclk(sclk), .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  function automatic int exp_div(input logic [4:0] i, input bit p2,
                                 input bit w, input bit d3);
    int pos;
    int cap;
    if (p2) return 4 << i[2:0];
    cap = w ? 18 : 16;
    pos = (int'(i) > cap) ? cap : int'(i);
    if (pos == 0 || (pos == 1 && !d3)) pos = 2;
    case (pos)
      1: return 3;     2: return 4;     3: return 6;     4: return 8;
      5: return 12;    6: return 16;    7: return 24;    8: return 32;
      9: return 48;    10: return 64;   11: return 96;   12: return 128;
      13: return 192;  14: return 256;  15: return 384;  16: return 512;
      17: return 768;  default: return 1024;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Disable, apply config, enable; ends at the negedge showing the first strobe.
  task automatic start(input logic [4:0] i, input bit p2, input bit w,
                       input bit d3, input bit pol);
    @(negedge clk);
    en = 1'b0; idx = i; pow2_sel = p2; wide_cap = w; div3_allow = d3; cpol = pol;
    @(negedge clk);
    chk(sclk == pol && !sample_stb && !shift_stb, "R2 idle level", int'(sclk), int'(pol));
    en = 1'b1;
    @(negedge clk);
    chk(sample_stb == 1'b1 && sclk == !pol, "R10 first period", int'(sample_stb), 1);
  endtask

  // Starts at a negedge where sample_stb was seen; times one period.
  task automatic measure(input int exp, input bit pol, input string req);
    int per = 0;
    int act = 1;
    int shpos = -1;
    bit both = 1'b0;
    for (int c = 1; c <= 2100; c++) begin
      @(negedge clk);
      if (sample_stb && shift_stb) both = 1'b1;
      if (sample_stb) begin per = c; break; end
      if (sclk != pol) act++;
      if (shift_stb) begin
        if (shpos >= 0) both = 1'b1;
        shpos = c;
      end
    end
    chk(per == exp, req, per, exp);
    chk(act == exp - exp / 2, "R7 active phase", act, exp - exp / 2);
    chk(shpos == exp - exp / 2 && !both, "R8 shift strobe position", shpos, exp - exp / 2);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a17));
    rst_n = 1'b0; en = 1'b0; idx = 5'd2; pow2_sel = 1'b0;
    wide_cap = 1'b0; div3_allow = 1'b0; cpol = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!sclk && !sample_stb && !shift_stb, "R1 reset state", int'(sclk), 0);
    end
    rst_n = 1'b1;

    // R3 whole ladder with the wide cap
    for (int i = 2; i <= 18; i++) begin
      start(5'(i), 1'b0, 1'b1, 1'b0, 1'b0);
      measure(exp_div(5'(i), 1'b0, 1'b1, 1'b0), 1'b0, "R3 table ratio");
    end

    // R4 odd ratio and reserved index
    start(5'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    measure(3, 1'b0, "R4 index 1 allowed");
    start(5'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    measure(4, 1'b1, "R4 index 1 blocked");
    start(5'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    measure(4, 1'b0, "R4 index 0");

    // R5 clamp at both caps
    start(5'd17, 1'b0, 1'b0, 1'b0, 1'b0);
    measure(512, 1'b0, "R5 narrow clamp 17");
    start(5'd31, 1'b0, 1'b0, 1'b0, 1'b1);
    measure(512, 1'b1, "R5 narrow clamp 31");
    start(5'd19, 1'b0, 1'b1, 1'b0, 1'b0);
    measure(1024, 1'b0, "R5 wide clamp 19");
    start(5'd31, 1'b0, 1'b1, 1'b0, 1'b0);
    measure(1024, 1'b0, "R5 wide clamp 31");

    // R6 power-of-two codes, upper bits randomised
    for (int c = 0; c < 8; c++) begin
      logic [4:0] v;
      v = {2'($urandom), 3'(c)};
      start(v, 1'b1, 1'($urandom), 1'($urandom), 1'b0);
      measure(4 << c, 1'b0, "R6 power-of-two ratio");
    end

    // R9 index change mid-period
    start(5'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    idx = 5'd6;
    measure(4, 1'b0, "R9 old ratio kept");
    measure(16, 1'b0, "R9 new ratio applied");

    // R9 polarity change mid-period
    start(5'd4, 1'b0, 1'b0, 1'b0, 1'b0);
    cpol = 1'b1;
    measure(8, 1'b0, "R9 old polarity kept");
    measure(8, 1'b1, "R9 new polarity applied");

    // R2 idle follows polarity while disabled
    @(negedge clk);
    en = 1'b0; cpol = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(sclk == 1'b1 && !sample_stb && !shift_stb, "R2 parked high", int'(sclk), 1);
    end
    cpol = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0 && !sample_stb && !shift_stb, "R2 parked low", int'(sclk), 0);

    // Random configurations
    for (int n = 0; n < 40; n++) begin
      logic [4:0] v;
      bit p2, w, d3, pol;
      v = 5'($urandom); p2 = 1'($urandom); w = 1'($urandom);
      d3 = 1'($urandom); pol = 1'($urandom);
      start(v, p2, w, d3, pol);
      measure(exp_div(v, p2, w, d3), pol, "R3 R5 R6 random ratio");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule